// File: doc/BRIEF.md
# Flash Array Pattern Scan Checker

This block exercises a page-organised NAND-style memory through a plain request/acknowledge port that carries a command, a block/page/column address and a write byte. After a start pulse it programs every location outside the bad-block list with one of four fixed byte patterns. It then reads the array pass after pass and compares each byte with the pattern it programmed. Each mismatch becomes a record on a valid/ready stream. The record gives the failing address, the byte read, the byte expected, how many bits differ, which way they flipped, a running error count and a counter of errors that share a block and page.

There are two run modes. In read-only mode a mismatch is reported and the scan moves on. In repair mode a mismatch is reported, the location is erased and programmed again with the pattern, and scanning resumes at the next address. A stop pulse ends the run. The block then makes one final read-only pass from address zero. That pass reports errors still present in the array, flags them as static, and counts them with a counter of their own. When the pass is finished the block goes idle.

Top module: `flash_scan`

## Requirements
- R1: `pat_sel_i` selects the byte programmed into every location: 0 gives 0x00, 1 gives 0xFF, 2 gives 0xAA, 3 gives 0x55. After start, the fill phase programs each location outside bad blocks exactly once.
- R2: Addresses advance with the column fastest, then the page, then the block. Columns run 0..COLS_PER_PAGE-1, so the spare area is included. Read passes repeat from address zero until a stop is seen.
- R3: Each record carries the byte read, the expected byte, the popcount of their XOR, and the block, page and column of the failing location. The address in the record is `{rec_blk_o, rec_page_o, rec_col_o}`.
- R4: `rec_up_o` is 1 when some bit reads 1 where 0 was expected. `rec_down_o` is 1 when some bit reads 0 where 1 was expected.
- R5: Run-phase records carry a count that is cleared at start and rises by one per record, so the first record carries 1.
- R6: The group counter is cleared at start. It rises by one when a mismatch is in the same block and page as the previous mismatch of the same pass. The previous-mismatch memory is forgotten at every pass start. Each record reports the counter value after any such increment.
- R7: In repair mode (`mode_rew_i`=1), after a run-phase record is accepted the block issues erase (cmd 3) and then program (cmd 2) of the expected byte to that address, and then continues at the next address. In read-only mode no erase or program is issued after the fill.
- R8: Up to MAX_BAD block numbers load in order through `bad_we_i`. Loads beyond MAX_BAD are ignored. `bad_clr_i` empties the list. Listed blocks receive no memory request of any kind.
- R9: While a record is valid and `rec_ready_i` is low, every record field holds steady and no memory request is issued.
- R10: A stop pulse, taken at the next address step of the run, starts one read-only pass from address zero. That pass sets `rec_static_o`, counts its records from 1 with a separate counter, and then returns the block to idle (`busy_o`=0).
- R11: After reset, and whenever idle, `busy_o`, `mem_req_o` and `rec_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| stop_i | input | 1 | Stop pulse, ends the run phase |
| mode_rew_i | input | 1 | 1: repair mode, 0: read-only, sampled at start |
| pat_sel_i | input | 2 | Pattern select, sampled at start |
| bad_clr_i | input | 1 | Empty the bad-block list |
| bad_we_i | input | 1 | Append `bad_blk_i` to the list |
| bad_blk_i | input | BLK_W | Block number to mark bad |
| busy_o | output | 1 | High from start until the final pass ends |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_cmd_o | output | 2 | 1 read, 2 program, 3 erase |
| mem_blk_o | output | BLK_W | Request block |
| mem_page_o | output | PAGE_W | Request page |
| mem_col_o | output | COL_W | Request column |
| mem_wdata_o | output | 8 | Program data |
| mem_ack_i | input | 1 | Request done; read data valid in the same cycle |
| mem_rdata_i | input | 8 | Read data |
| rec_valid_o | output | 1 | Error record valid |
| rec_ready_i | input | 1 | Error record accepted |
| rec_count_o | output | CNT_W | Run or static error count |
| rec_data_o | output | 8 | Byte read |
| rec_exp_o | output | 8 | Byte expected |
| rec_nbits_o | output | 4 | Bits in error |
| rec_up_o | output | 1 | Some 0-to-1 flip |
| rec_down_o | output | 1 | Some 1-to-0 flip |
| rec_blk_o | output | BLK_W | Failing block |
| rec_page_o | output | PAGE_W | Failing page |
| rec_col_o | output | COL_W | Failing column |
| rec_group_o | output | CNT_W | Same-page multi-error counter |
| rec_static_o | output | 1 | Record from the final pass |

## Verification
Each of the four patterns is run against a corruption mask chosen to tell the cases apart. With 0x00 only upward flips are possible. With 0xFF only downward flips occur, and two of them. Against 0xAA the mask gives a flip in each direction in one byte. Against 0x55 a single downward flip is checked in an upper bit. Together these separate the pattern encoding, the polarity flags and the popcount. Three errors placed in one page and then another page are read back in the final pass, which checks the scan order, the separate static count and the group counter. Further runs cover the repair mode, a full bad-block list with one surplus load, and a record held back against stalled readiness.

// File: rtl/flash_scan_pkg.sv
package flash_scan_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_PROG  = 2'd2,
    CMD_ERASE = 2'd3
  } mem_cmd_e;

  typedef enum logic [1:0] {PH_FILL, PH_RUN, PH_POST} phase_e;

  typedef enum logic [2:0] {ST_IDLE, ST_ACC, ST_REC, ST_ERASE, ST_PROG} state_e;

  function automatic logic [7:0] pattern_byte(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'h00;
      2'd1:    return 8'hFF;
      2'd2:    return 8'hAA;
      default: return 8'h55;
    endcase
  endfunction

endpackage

// File: rtl/flash_scan_addr.sv
module flash_scan_addr #(
  parameter int NUM_BLOCKS      = 4096,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int COLS_PER_PAGE   = 2112,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int PAGE_W = $clog2(PAGES_PER_BLOCK),
  localparam int COL_W  = $clog2(COLS_PER_PAGE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_loc_i,
  input  logic              step_blk_i,
  output logic [BLK_W-1:0]  blk_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [COL_W-1:0]  col_o,
  output logic              wrap_o
);

  logic last_blk, last_page, last_col;

  assign last_blk  = blk_o  == BLK_W'(NUM_BLOCKS - 1);
  assign last_page = page_o == PAGE_W'(PAGES_PER_BLOCK - 1);
  assign last_col  = col_o  == COL_W'(COLS_PER_PAGE - 1);
  assign wrap_o    = step_blk_i ? last_blk
                   : (step_loc_i & last_blk & last_page & last_col);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_o  <= '0;
      page_o <= '0;
      col_o  <= '0;
    end else if (clr_i) begin
      blk_o  <= '0;
      page_o <= '0;
      col_o  <= '0;
    end else if (step_blk_i) begin
      col_o  <= '0;
      page_o <= '0;
      blk_o  <= last_blk ? '0 : blk_o + 1'b1;
    end else if (step_loc_i) begin
      col_o <= last_col ? '0 : col_o + 1'b1;
      if (last_col) begin
        page_o <= last_page ? '0 : page_o + 1'b1;
        if (last_page) blk_o <= last_blk ? '0 : blk_o + 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_scan_badlist.sv
module flash_scan_badlist #(
  parameter int MAX_BAD = 80,
  parameter int BLK_W   = 12,
  localparam int PTR_W  = $clog2(MAX_BAD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [BLK_W-1:0] query_i,
  output logic             hit_o
);

  logic [PTR_W-1:0]   ptr_q;
  logic [MAX_BAD-1:0] match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ptr_q <= '0;
    else if (clr_i)                                ptr_q <= '0;
    else if (we_i && ptr_q != PTR_W'(MAX_BAD))     ptr_q <= ptr_q + 1'b1;
  end

  for (genvar i = 0; i < MAX_BAD; i++) begin : g_entry
    logic [BLK_W-1:0] tag_q;
    logic             vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q <= '0;
        vld_q <= 1'b0;
      end else if (clr_i) begin
        vld_q <= 1'b0;
      end else if (we_i && ptr_q == PTR_W'(i)) begin
        tag_q <= blk_i;
        vld_q <= 1'b1;
      end
    end
    assign match[i] = vld_q && (tag_q == query_i);
  end

  assign hit_o = |match;

endmodule

// File: rtl/flash_scan_cmp.sv
module flash_scan_cmp (
  input  logic [7:0] exp_i,
  input  logic [7:0] rd_i,
  output logic       mism_o,
  output logic [3:0] nbits_o,
  output logic       up_o,
  output logic       down_o
);

  logic [7:0] diff;

  assign diff   = exp_i ^ rd_i;
  assign mism_o = |diff;
  assign up_o   = |(rd_i & ~exp_i);
  assign down_o = |(~rd_i & exp_i);

  always_comb begin
    nbits_o = '0;
    for (int i = 0; i < 8; i++) nbits_o = nbits_o + {3'b000, diff[i]};
  end

endmodule

// File: rtl/flash_scan.sv
module flash_scan
  import flash_scan_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4096,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int COLS_PER_PAGE   = 2112,
  parameter int MAX_BAD         = 80,
  parameter int CNT_W           = 16,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int PAGE_W = $clog2(PAGES_PER_BLOCK),
  localparam int COL_W  = $clog2(COLS_PER_PAGE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              mode_rew_i,
  input  logic [1:0]        pat_sel_i,
  input  logic              bad_clr_i,
  input  logic              bad_we_i,
  input  logic [BLK_W-1:0]  bad_blk_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [1:0]        mem_cmd_o,
  output logic [BLK_W-1:0]  mem_blk_o,
  output logic [PAGE_W-1:0] mem_page_o,
  output logic [COL_W-1:0]  mem_col_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [CNT_W-1:0]  rec_count_o,
  output logic [7:0]        rec_data_o,
  output logic [7:0]        rec_exp_o,
  output logic [3:0]        rec_nbits_o,
  output logic              rec_up_o,
  output logic              rec_down_o,
  output logic [BLK_W-1:0]  rec_blk_o,
  output logic [PAGE_W-1:0] rec_page_o,
  output logic [COL_W-1:0]  rec_col_o,
  output logic [CNT_W-1:0]  rec_group_o,
  output logic              rec_static_o
);

  state_e            state_q;
  phase_e            phase_q;
  logic              mode_q, stop_q, prev_vld_q;
  logic [7:0]        pat_q;
  logic [BLK_W-1:0]  blk, prev_blk_q;
  logic [PAGE_W-1:0] page, prev_page_q;
  logic [COL_W-1:0]  col;
  logic [CNT_W-1:0]  run_cnt_q, stat_cnt_q, group_q;
  logic              bad_hit, mism, up, down, wrap;
  logic [3:0]        nbits;
  logic              acc, rew_path, start_ok, rd_done, capture, same_pg;
  logic              step_loc, step_blk, advance, end_pass, go_post, addr_clr;
  mem_cmd_e          cmd;

  flash_scan_addr #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .COLS_PER_PAGE(COLS_PER_PAGE)
  ) u_addr (
    .clk_i, .rst_ni, .clr_i(addr_clr), .step_loc_i(step_loc), .step_blk_i(step_blk),
    .blk_o(blk), .page_o(page), .col_o(col), .wrap_o(wrap)
  );

  flash_scan_badlist #(.MAX_BAD(MAX_BAD), .BLK_W(BLK_W)) u_bad (
    .clk_i, .rst_ni, .clr_i(bad_clr_i), .we_i(bad_we_i), .blk_i(bad_blk_i),
    .query_i(blk), .hit_o(bad_hit)
  );

  flash_scan_cmp u_cmp (
    .exp_i(pat_q), .rd_i(mem_rdata_i), .mism_o(mism), .nbits_o(nbits), .up_o(up), .down_o(down)
  );

  assign start_ok = (state_q == ST_IDLE) && start_i;
  assign acc      = state_q == ST_ACC;
  assign rew_path = mode_q && (phase_q == PH_RUN);
  assign rd_done  = acc && !bad_hit && mem_ack_i;
  assign capture  = rd_done && (phase_q != PH_FILL) && mism;
  assign step_blk = acc && bad_hit;
  assign step_loc = (rd_done && !capture)
                  || (state_q == ST_REC && rec_ready_i && !rew_path)
                  || (state_q == ST_PROG && mem_ack_i);
  assign advance  = step_loc || step_blk;
  assign end_pass = advance && wrap;
  assign go_post  = advance && (phase_q == PH_RUN) && stop_q;
  assign addr_clr = start_ok || go_post;
  assign same_pg  = prev_vld_q && (blk == prev_blk_q) && (page == prev_page_q);

  always_comb begin
    cmd = CMD_NONE;
    case (state_q)
      ST_ACC:   if (!bad_hit) cmd = (phase_q == PH_FILL) ? CMD_PROG : CMD_READ;
      ST_ERASE: cmd = CMD_ERASE;
      ST_PROG:  cmd = CMD_PROG;
      default:  cmd = CMD_NONE;
    endcase
  end

  assign mem_req_o   = cmd != CMD_NONE;
  assign mem_cmd_o   = cmd;
  assign mem_blk_o   = blk;
  assign mem_page_o  = page;
  assign mem_col_o   = col;
  assign mem_wdata_o = pat_q;
  assign busy_o      = state_q != ST_IDLE;
  assign rec_valid_o = state_q == ST_REC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;     phase_q <= PH_FILL;
      mode_q <= 1'b0;         stop_q <= 1'b0;       pat_q <= '0;
      prev_vld_q <= 1'b0;     prev_blk_q <= '0;     prev_page_q <= '0;
      run_cnt_q <= '0;        stat_cnt_q <= '0;     group_q <= '0;
      rec_count_o <= '0;      rec_data_o <= '0;     rec_exp_o <= '0;
      rec_nbits_o <= '0;      rec_up_o <= 1'b0;     rec_down_o <= 1'b0;
      rec_blk_o <= '0;        rec_page_o <= '0;     rec_col_o <= '0;
      rec_group_o <= '0;      rec_static_o <= 1'b0;
    end else begin
      if (busy_o && stop_i) stop_q <= 1'b1;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q    <= ST_ACC;
          phase_q    <= PH_FILL;
          mode_q     <= mode_rew_i;
          pat_q      <= pattern_byte(pat_sel_i);
          stop_q     <= 1'b0;
          prev_vld_q <= 1'b0;
          run_cnt_q  <= '0;
          stat_cnt_q <= '0;
          group_q    <= '0;
        end
        ST_ACC: if (capture) begin
          state_q      <= ST_REC;
          rec_data_o   <= mem_rdata_i;
          rec_exp_o    <= pat_q;
          rec_nbits_o  <= nbits;
          rec_up_o     <= up;
          rec_down_o   <= down;
          rec_blk_o    <= blk;
          rec_page_o   <= page;
          rec_col_o    <= col;
          rec_static_o <= phase_q == PH_POST;
          if (phase_q == PH_POST) begin
            stat_cnt_q  <= stat_cnt_q + 1'b1;
            rec_count_o <= stat_cnt_q + 1'b1;
          end else begin
            run_cnt_q   <= run_cnt_q + 1'b1;
            rec_count_o <= run_cnt_q + 1'b1;
          end
          group_q     <= same_pg ? group_q + 1'b1 : group_q;
          rec_group_o <= same_pg ? group_q + 1'b1 : group_q;
          prev_vld_q  <= 1'b1;
          prev_blk_q  <= blk;
          prev_page_q <= page;
        end
        ST_REC:   if (rec_ready_i && rew_path) state_q <= ST_ERASE;
        ST_ERASE: if (mem_ack_i) state_q <= ST_PROG;
        default: ;
      endcase
      if (advance) begin
        state_q <= (end_pass && phase_q == PH_POST) ? ST_IDLE : ST_ACC;
        if (go_post) begin
          phase_q    <= PH_POST;
          stop_q     <= 1'b0;
          prev_vld_q <= 1'b0;
        end else if (end_pass) begin
          prev_vld_q <= 1'b0;
          if (phase_q == PH_FILL) phase_q <= PH_RUN;
        end
      end
    end
  end

endmodule

// File: rtl/flash_scan_chk.sv
module flash_scan_chk #(
  parameter int BLK_W  = 12,
  parameter int PAGE_W = 6,
  parameter int COL_W  = 12,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic [1:0]        mem_cmd_o,
  input logic              rec_valid_o,
  input logic              rec_ready_i,
  input logic [CNT_W-1:0]  rec_count_o,
  input logic [7:0]        rec_data_o,
  input logic [7:0]        rec_exp_o,
  input logic [3:0]        rec_nbits_o,
  input logic              rec_up_o,
  input logic              rec_down_o,
  input logic [BLK_W-1:0]  rec_blk_o,
  input logic [PAGE_W-1:0] rec_page_o,
  input logic [COL_W-1:0]  rec_col_o,
  input logic              mode_q
);

  assert_rec_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_data_o) && $stable(rec_count_o)
      && $stable(rec_blk_o) && $stable(rec_page_o) && $stable(rec_col_o));

  assert_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> !mem_req_o);

  assert_mismatch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_data_o != rec_exp_o)
      && (rec_nbits_o == 4'($countones(rec_data_o ^ rec_exp_o))));

  assert_polarity_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_up_o || rec_down_o));

  assert_ro_no_erase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mode_q |-> mem_cmd_o != 2'd3);

  assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !rec_valid_o);

endmodule

bind flash_scan flash_scan_chk #(
  .BLK_W(BLK_W), .PAGE_W(PAGE_W), .COL_W(COL_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .mem_req_o(mem_req_o),
  .mem_cmd_o(mem_cmd_o), .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i),
  .rec_count_o(rec_count_o), .rec_data_o(rec_data_o), .rec_exp_o(rec_exp_o),
  .rec_nbits_o(rec_nbits_o), .rec_up_o(rec_up_o), .rec_down_o(rec_down_o),
  .rec_blk_o(rec_blk_o), .rec_page_o(rec_page_o), .rec_col_o(rec_col_o),
  .mode_q(mode_q)
);

// File: tb/tb_flash_scan.sv
module tb_flash_scan;

  localparam int NB = 4, NP = 2, NC = 8, MB = 3, CW = 16;
  localparam int NLOC = NB * NP * NC;

  localparam logic [1:0] V_SEL  [4] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [7:0] V_PAT  [4] = '{8'h00, 8'hFF, 8'hAA, 8'h55};
  localparam logic [5:0] V_LOC  [4] = '{6'd5, 6'd22, 6'd41, 6'd63};
  localparam logic [7:0] V_MASK [4] = '{8'h02, 8'h81, 8'h03, 8'h10};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, mode = 0, ready = 0, bad_clr = 0, bad_we = 0;
  logic [1:0] sel = 0;
  logic [1:0] bad_blk = 0;
  logic busy, req, ack, rvalid, up, down, stat;
  logic [1:0] cmd, mblk, rblk;
  logic [0:0] mpage, rpage;
  logic [2:0] mcol, rcol;
  logic [7:0] wdata, rdata, rd, rexp;
  logic [3:0] nbits;
  logic [CW-1:0] rcnt, rgrp;

  always #2.5 clk = ~clk;

  flash_scan #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(NP), .COLS_PER_PAGE(NC), .MAX_BAD(MB), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .mode_rew_i(mode), .pat_sel_i(sel),
    .bad_clr_i(bad_clr), .bad_we_i(bad_we), .bad_blk_i(bad_blk), .busy_o(busy),
    .mem_req_o(req), .mem_cmd_o(cmd), .mem_blk_o(mblk), .mem_page_o(mpage), .mem_col_o(mcol),
    .mem_wdata_o(wdata), .mem_ack_i(ack), .mem_rdata_i(rdata),
    .rec_valid_o(rvalid), .rec_ready_i(ready), .rec_count_o(rcnt), .rec_data_o(rd), .rec_exp_o(rexp),
    .rec_nbits_o(nbits), .rec_up_o(up), .rec_down_o(down), .rec_blk_o(rblk), .rec_page_o(rpage),
    .rec_col_o(rcol), .rec_group_o(rgrp), .rec_static_o(stat)
  );

  // behavioural memory
  logic [7:0] mem [NLOC];
  int wr_cnt, rd_cnt, er_cnt;
  logic [NB-1:0] touched;
  logic inj_go = 0, fill_go = 0, clr_stats = 0;
  logic [5:0] inj_loc = 0;
  logic [7:0] inj_mask = 0, fill_val = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0; rdata <= '0; wr_cnt <= 0; rd_cnt <= 0; er_cnt <= 0; touched <= '0;
    end else begin
      ack <= 1'b0;
      if (clr_stats) begin wr_cnt <= 0; rd_cnt <= 0; er_cnt <= 0; touched <= '0; end
      if (fill_go) for (int i = 0; i < NLOC; i++) mem[i] <= fill_val;
      if (inj_go) mem[inj_loc] <= mem[inj_loc] ^ inj_mask;
      if (req && !ack) begin
        ack <= 1'b1;
        touched[mblk] <= 1'b1;
        case (cmd)
          2'd1: begin rdata <= mem[{mblk, mpage, mcol}]; rd_cnt <= rd_cnt + 1; end
          2'd2: begin mem[{mblk, mpage, mcol}] <= wdata; wr_cnt <= wr_cnt + 1; end
          2'd3: begin mem[{mblk, mpage, mcol}] <= 8'hFF; er_cnt <= er_cnt + 1; end
          default: ;
        endcase
      end
    end
  end

  int checks = 0, fails = 0;
  int nstat;
  logic [5:0] s_loc [4];
  logic [CW-1:0] s_cnt [4], s_grp [4];
  logic [7:0] s_data [4];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_stats();
    @(negedge clk) clr_stats = 1;
    @(negedge clk) clr_stats = 0;
  endtask

  task automatic inject(input logic [5:0] loc, input logic [7:0] m);
    @(negedge clk) begin inj_go = 1; inj_loc = loc; inj_mask = m; end
    @(negedge clk) inj_go = 0;
  endtask

  task automatic start_run(input logic m, input logic [1:0] s);
    @(negedge clk) begin mode = m; sel = s; start = 1; end
    @(negedge clk) start = 0;
  endtask

  task automatic wait_writes(input int n, output bit ok);
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (wr_cnt >= n) begin ok = 1; break; end
    end
  endtask

  task automatic wait_rec(output bit got);
    got = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (rvalid) begin got = 1; break; end
    end
  endtask

  task automatic pop_rec();
    @(negedge clk) ready = 1;
    @(negedge clk) ready = 0;
  endtask

  task automatic drain_post(output bit idle);
    idle = 0;
    nstat = 0;
    @(negedge clk) begin stop = 1; ready = 1; end
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      stop = 0;
      if (rvalid && stat && nstat < 4) begin
        s_loc[nstat] = {rblk, rpage, rcol};
        s_cnt[nstat] = rcnt;
        s_grp[nstat] = rgrp;
        s_data[nstat] = rd;
        nstat++;
      end
      if (!busy) begin idle = 1; break; end
    end
    ready = 0;
  endtask

  task automatic load_bad(input logic [1:0] b);
    @(negedge clk) begin bad_we = 1; bad_blk = b; end
    @(negedge clk) bad_we = 0;
  endtask

  function automatic int count_ne(input int lo, input int hi, input logic [7:0] v);
    int n = 0;
    for (int i = lo; i < hi; i++) if (mem[i] !== v) n++;
    return n;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    bit ok, got, idle;
    int ops0, nrec;
    logic [7:0] held;
    cyc(3);
    chk(!busy && !req && !rvalid, "R11 reset idle", {busy, req, rvalid}, 0);
    @(negedge clk) rst_n = 1;
    cyc(2);
    chk(!busy && !req && !rvalid, "R11 after reset release", {busy, req, rvalid}, 0);

    // pattern / mask vectors, read-only mode
    for (int v = 0; v < 4; v++) begin
      logic [7:0] p, m, e;
      p = V_PAT[v]; m = V_MASK[v]; e = p ^ m;
      clear_stats();
      start_run(1'b0, V_SEL[v]);
      wait_writes(NLOC, ok);
      cyc(4);
      chk(ok && wr_cnt == NLOC, "R1 fill write count", wr_cnt, NLOC);
      chk(count_ne(0, NLOC, p) == 0, "R1 fill pattern", count_ne(0, NLOC, p), 0);
      inject(V_LOC[v], m);
      wait_rec(got);
      chk(got, "R3 record present", got, 1);
      chk(rd == e && rexp == p, "R3 data/expected", {rd, rexp}, {e, p});
      chk(nbits == 4'($countones(m)), "R3 bit count", nbits, $countones(m));
      chk({rblk, rpage, rcol} == V_LOC[v], "R3 address", {rblk, rpage, rcol}, V_LOC[v]);
      chk(up == |(m & ~p) && down == |(m & p), "R4 polarity", {up, down}, {|(m & ~p), |(m & p)});
      chk(rcnt == 1 && !stat, "R5 first run count", rcnt, 1);
      if (v == 0) begin
        held = rd;
        ops0 = wr_cnt + rd_cnt + er_cnt;
        cyc(40);
        chk(rvalid && rd == held, "R9 record held", {rvalid, rd}, {1'b1, held});
        chk(wr_cnt + rd_cnt + er_cnt == ops0, "R9 scan stalled", wr_cnt + rd_cnt + er_cnt, ops0);
      end
      chk(er_cnt == 0 && wr_cnt == NLOC, "R7 read-only no rewrite", er_cnt, 0);
      drain_post(idle);
      chk(nstat >= 1 && s_loc[0] == V_LOC[v] && s_cnt[0] == 1 && s_data[0] == e,
          "R10 static record", s_loc[0], V_LOC[v]);
      chk(idle && !busy, "R10 idle after final pass", busy, 0);
    end

    // scan order, static count and group counter
    clear_stats();
    start_run(1'b0, 2'd0);
    wait_writes(NLOC, ok);
    cyc(4);
    inject(6'd16, 8'h01);
    inject(6'd19, 8'h04);
    inject(6'd40, 8'h80);
    cyc(300);
    drain_post(idle);
    chk(nstat == 3, "R10 static error count", nstat, 3);
    chk(s_loc[0] == 16 && s_loc[1] == 19 && s_loc[2] == 40, "R2 scan order",
        {s_loc[0], s_loc[1], s_loc[2]}, {6'd16, 6'd19, 6'd40});
    chk(s_cnt[0] == 1 && s_cnt[1] == 2 && s_cnt[2] == 3, "R10 static count sequence", s_cnt[2], 3);
    chk(s_grp[1] == s_grp[0] + 1, "R6 same page increments group", s_grp[1], s_grp[0] + 1);
    chk(s_grp[2] == s_grp[1], "R6 new page keeps group", s_grp[2], s_grp[1]);

    // repair mode
    clear_stats();
    start_run(1'b1, 2'd2);
    wait_writes(NLOC, ok);
    cyc(4);
    inject(6'd30, 8'h01);
    wait_rec(got);
    chk(got && rd == 8'hAB && rcnt == 1, "R7 repair-mode record", rd, 8'hAB);
    pop_rec();
    cyc(20);
    chk(mem[30] == 8'hAA, "R7 location rewritten", mem[30], 8'hAA);
    chk(er_cnt == 1 && wr_cnt == NLOC + 1, "R7 one erase one program", {er_cnt[7:0], wr_cnt[7:0]}, {8'd1, 8'(NLOC + 1)});
    nrec = 0;
    ready = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rvalid) nrec++;
    end
    ready = 0;
    chk(nrec == 0, "R7 no repeat after repair", nrec, 0);
    drain_post(idle);
    chk(nstat == 0 && idle, "R10 no static errors after repair", nstat, 0);

    // bad blocks: list full at three, fourth load ignored
    @(negedge clk) bad_clr = 1;
    @(negedge clk) bad_clr = 0;
    load_bad(2'd0); load_bad(2'd1); load_bad(2'd2); load_bad(2'd3);
    @(negedge clk) begin fill_go = 1; fill_val = 8'h3C; end
    @(negedge clk) fill_go = 0;
    clear_stats();
    start_run(1'b0, 2'd0);
    wait_writes(16, ok);
    cyc(300);
    chk(ok && wr_cnt == 16, "R8 only good block filled", wr_cnt, 16);
    chk(touched[2:0] == 3'b000 && touched[3], "R8 bad blocks untouched", touched, 4'b1000);
    chk(count_ne(0, 48, 8'h3C) == 0 && count_ne(48, 64, 8'h00) == 0, "R8 contents", count_ne(0, 48, 8'h3C), 0);
    chk(!rvalid, "R8 no records from skipped blocks", rvalid, 0);
    drain_post(idle);
    chk(nstat == 0 && idle, "R8 final pass skips bad blocks", nstat, 0);

    // list clear
    @(negedge clk) bad_clr = 1;
    @(negedge clk) bad_clr = 0;
    clear_stats();
    start_run(1'b0, 2'd1);
    wait_writes(NLOC, ok);
    cyc(4);
    chk(ok && wr_cnt == NLOC && count_ne(0, NLOC, 8'hFF) == 0, "R8 cleared list fills all", wr_cnt, NLOC);
    drain_post(idle);
    chk(idle && !busy && !req, "R11 idle at end", {busy, req}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule